// File: doc/BRIEF.md
# Codec Input-Frame Serializer

This block sits on the codec side of a five-wire audio link and turns one parallel snapshot of capture data into the serial input frame that returns to the controller. It watches the frame-sync line on every bit clock. When it sees sync go from low to high, it captures the codec-ready flag, the register-read return words, the left and right samples with their valid flags, and the resolution setting. It then shifts a 256-bit frame out on its serial output, one bit per bit clock.

The frame starts with a 16-bit tag slot. Twelve 20-bit data slots follow, and every field is sent most significant bit first. The tag marks which slots hold data. Slots 1 and 2 carry the register-read address and data words. Slots 3 and 4 carry the left and right samples. Each sample sits at the top of its 20-bit slot, and the positions below the selected resolution are zero. Slots 5 to 12 are never used and always carry zeros. A later update to the inputs only reaches the next frame.

Top module: `aclink_infrm_ser`

## Requirements
- R1: Let sync be sampled high at bit-clock edge E while it was sampled low at edge E-1. Bit k (0..255) of the frame then appears on `sdata_o` after edge E+1+k. The frame is a 16-bit tag followed by twelve 20-bit slots, each field sent MSB first.
- R2: While no frame is in progress, `sdata_o` is 0. Sync that stays high does not start another frame; sync must first be sampled low.
- R3: Tag bit 15 is codec-ready. Bit 14 and bit 13 are both `rd_valid_i` (slots 1 and 2). Bit 12 is `left_valid_i` and bit 11 is `right_valid_i`. Bits 10 down to 0 are 0.
- R4: Slot 1 carries `rd_addr_i` and slot 2 carries `rd_data_i` when `rd_valid_i` is 1. Otherwise both slots are all zeros.
- R5: Slot 3 carries the left sample and slot 4 carries the right sample when the matching valid flag is 1. Otherwise the slot is all zeros.
- R6: `res_sel_i` selects the sample resolution: 0 gives 16 bits, 1 gives 18 bits, and 2 or 3 gives 20 bits. Samples are MSB-aligned at bit 19, and the 4 (16-bit) or 2 (18-bit) low positions are sent as 0 whatever the input holds.
- R7: Slots 5 through 12 are sent as all zeros.
- R8: All frame contents are captured at edge E. A change on any data input during the frame has no effect on that frame.
- R9: A new sync rising edge in the middle of a frame abandons the current frame. A new frame then starts with the same timing as R1.
- R10: During and after reset, with sync low, `sdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock; output changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| sync_in | input | 1 | Frame sync from the controller |
| codec_ready_i | input | 1 | Codec-ready flag for tag bit 15 |
| res_sel_i | input | 2 | Sample resolution select (0:16, 1:18, 2/3:20) |
| rd_valid_i | input | 1 | Register-read return present in slots 1 and 2 |
| rd_addr_i | input | 20 | Slot 1 word (read address echo) |
| rd_data_i | input | 20 | Slot 2 word (read data) |
| left_valid_i | input | 1 | Left sample valid |
| left_sample_i | input | 20 | Left sample, MSB at bit 19 |
| right_valid_i | input | 1 | Right sample valid |
| right_sample_i | input | 20 | Right sample, MSB at bit 19 |
| sdata_o | output | 1 | Serial input-frame data |

## Verification
A slot counter that is off by one shifts every later field. The wrong bit then shows up at the first slot boundary, within 20 bit times of the fault, and a frame-length error shows as a nonzero bit after bit 255. A snapshot that follows the live inputs shows up at the first bit sent after an input changes mid-frame. A wrong resolution mask shows up on the low bits at the end of slot 3 or slot 4. The bench compares every bit of every frame against an expected frame built by division-based slot arithmetic. It does this across all resolutions and all valid-flag combinations, with the inputs disturbed in the middle of each frame.

// File: rtl/aclink_infrm_pkg.sv
package aclink_infrm_pkg;

  localparam int TAG_BITS  = 16;
  localparam int SLOT_BITS = 20;
  localparam int DATA_SLOTS = 12;

  typedef logic [SLOT_BITS-1:0] slot_word_t;

  typedef enum logic [1:0] {
    RES_16  = 2'd0,
    RES_18  = 2'd1,
    RES_20  = 2'd2,
    RES_20X = 2'd3
  } res_e;

  typedef struct packed {
    logic             ready;
    res_e             res;
    logic [TAG_BITS-1:0] tag;
    slot_word_t       w1;
    slot_word_t       w2;
    slot_word_t       w3;
    slot_word_t       w4;
  } snap_t;

  // Number of low positions forced to zero for a resolution.
  function automatic int unsigned pad_bits(res_e r);
    case (r)
      RES_16:  return 4;
      RES_18:  return 2;
      default: return 0;
    endcase
  endfunction

  // Keep the MSB-aligned sample and zero its tail.
  function automatic slot_word_t justify(slot_word_t s, res_e r);
    slot_word_t keep;
    keep = '1;
    keep = keep << pad_bits(r);
    return s & keep;
  endfunction

  function automatic logic [TAG_BITS-1:0] build_tag(logic rdy, logic rdv,
                                                    logic lv, logic rv);
    logic [TAG_BITS-1:0] t;
    t = '0;
    t[TAG_BITS-1] = rdy;
    t[TAG_BITS-2] = rdv;
    t[TAG_BITS-3] = rdv;
    t[TAG_BITS-4] = lv;
    t[TAG_BITS-5] = rv;
    return t;
  endfunction

endpackage

// File: rtl/aclink_sync_edge.sv
module aclink_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic start_o
);
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_in;
  end

  assign start_o = sync_in & ~sync_q;

  // R2: two starts never occur on consecutive edges
  p_no_double_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

endmodule

// File: rtl/aclink_slot_counter.sv
module aclink_slot_counter #(
  parameter int TAG_W   = 16,
  parameter int SLOT_W  = 20,
  parameter int NSLOTS  = 12,
  localparam int SIW    = $clog2(NSLOTS + 1),
  localparam int BPW    = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  output logic           active_o,
  output logic [SIW-1:0] slot_o,
  output logic [BPW-1:0] bitpos_o
);
  localparam logic [SIW-1:0] LAST_SLOT = SIW'(NSLOTS);
  localparam logic [BPW-1:0] TAG_TOP   = BPW'(TAG_W - 1);
  localparam logic [BPW-1:0] SLOT_TOP  = BPW'(SLOT_W - 1);

  logic slot_done, frame_done;
  assign slot_done  = (bitpos_o == '0);
  assign frame_done = slot_done && (slot_o == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      slot_o   <= '0;
      bitpos_o <= '0;
    end else if (start_i) begin
      active_o <= 1'b1;
      slot_o   <= '0;
      bitpos_o <= TAG_TOP;
    end else if (active_o) begin
      if (frame_done) begin
        active_o <= 1'b0;
        slot_o   <= '0;
      end else if (slot_done) begin
        slot_o   <= slot_o + 1'b1;
        bitpos_o <= SLOT_TOP;
      end else begin
        bitpos_o <= bitpos_o - 1'b1;
      end
    end
  end

  p_start_loads_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_o && slot_o == '0 && bitpos_o == TAG_TOP));

  p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !start_i && bitpos_o == '0 && slot_o != LAST_SLOT)
      |=> (bitpos_o == SLOT_TOP && slot_o == $past(slot_o) + 1'b1));

  p_frame_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !start_i && slot_o == LAST_SLOT && bitpos_o == '0)
      |=> !active_o);

endmodule

// File: rtl/aclink_frame_snap.sv
module aclink_frame_snap
  import aclink_infrm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       ready_i,
  input  logic [1:0] res_i,
  input  logic       rd_valid_i,
  input  slot_word_t rd_addr_i,
  input  slot_word_t rd_data_i,
  input  logic       lv_i,
  input  slot_word_t left_i,
  input  logic       rv_i,
  input  slot_word_t right_i,
  output snap_t      snap_o
);
  snap_t nxt;
  res_e  r;

  always_comb begin
    r          = res_e'(res_i);
    nxt.ready  = ready_i;
    nxt.res    = r;
    nxt.tag    = build_tag(ready_i, rd_valid_i, lv_i, rv_i);
    nxt.w1     = rd_valid_i ? rd_addr_i : '0;
    nxt.w2     = rd_valid_i ? rd_data_i : '0;
    nxt.w3     = lv_i ? justify(left_i, r)  : '0;
    nxt.w4     = rv_i ? justify(right_i, r) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_o <= '0;
    else if (start_i) snap_o <= nxt;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(snap_o));

endmodule

// File: rtl/aclink_bit_select.sv
module aclink_bit_select
  import aclink_infrm_pkg::*;
#(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20,
  parameter int NSLOTS = 12,
  localparam int SIW   = $clog2(NSLOTS + 1),
  localparam int BPW   = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W),
  localparam int TIW   = $clog2(TAG_W),
  localparam int NWORD = 2 ** SIW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           active_i,
  input  logic [SIW-1:0] slot_i,
  input  logic [BPW-1:0] bitpos_i,
  input  snap_t          snap_i,
  output logic           bit_o
);
  logic [SLOT_W-1:0] words [NWORD];

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    if (g == 1)      begin : g_s1 assign words[g] = snap_i.w1; end
    else if (g == 2) begin : g_s2 assign words[g] = snap_i.w2; end
    else if (g == 3) begin : g_s3 assign words[g] = snap_i.w3; end
    else if (g == 4) begin : g_s4 assign words[g] = snap_i.w4; end
    else             begin : g_z  assign words[g] = '0;        end
  end

  logic tag_bit, data_bit;
  assign tag_bit  = snap_i.tag[bitpos_i[TIW-1:0]];
  assign data_bit = words[slot_i][bitpos_i];
  assign bit_o    = (slot_i == '0) ? tag_bit : data_bit;

  // R7: unused and reserved slots stay zero
  p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && slot_i >= SIW'(5)) |-> !bit_o);

  // R6: tail below 16-bit resolution is zero in the audio slots
  p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && (slot_i == SIW'(3) || slot_i == SIW'(4)) &&
     snap_i.res == RES_16 && bitpos_i < BPW'(4)) |-> !bit_o);

endmodule

// File: rtl/aclink_infrm_ser.sv
module aclink_infrm_ser
  import aclink_infrm_pkg::*;
(
  input  logic        clk_bit,
  input  logic        rst_n,
  input  logic        sync_in,
  input  logic        codec_ready_i,
  input  logic [1:0]  res_sel_i,
  input  logic        rd_valid_i,
  input  logic [19:0] rd_addr_i,
  input  logic [19:0] rd_data_i,
  input  logic        left_valid_i,
  input  logic [19:0] left_sample_i,
  input  logic        right_valid_i,
  input  logic [19:0] right_sample_i,
  output logic        sdata_o
);
  localparam int SIW = $clog2(DATA_SLOTS + 1);
  localparam int BPW = $clog2((TAG_BITS > SLOT_BITS) ? TAG_BITS : SLOT_BITS);

  logic           frame_start;
  logic           frame_active;
  logic [SIW-1:0] cur_slot;
  logic [BPW-1:0] cur_bit;
  logic           next_bit;
  snap_t          snap;

  aclink_sync_edge u_edge (
    .clk(clk_bit), .rst_n(rst_n), .sync_in(sync_in), .start_o(frame_start)
  );

  aclink_slot_counter #(.TAG_W(TAG_BITS), .SLOT_W(SLOT_BITS), .NSLOTS(DATA_SLOTS)) u_cnt (
    .clk(clk_bit), .rst_n(rst_n), .start_i(frame_start),
    .active_o(frame_active), .slot_o(cur_slot), .bitpos_o(cur_bit)
  );

  aclink_frame_snap u_snap (
    .clk(clk_bit), .rst_n(rst_n), .start_i(frame_start),
    .ready_i(codec_ready_i), .res_i(res_sel_i),
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .rd_data_i(rd_data_i),
    .lv_i(left_valid_i), .left_i(left_sample_i),
    .rv_i(right_valid_i), .right_i(right_sample_i),
    .snap_o(snap)
  );

  aclink_bit_select #(.TAG_W(TAG_BITS), .SLOT_W(SLOT_BITS), .NSLOTS(DATA_SLOTS)) u_sel (
    .clk(clk_bit), .rst_n(rst_n), .active_i(frame_active),
    .slot_i(cur_slot), .bitpos_i(cur_bit), .snap_i(snap), .bit_o(next_bit)
  );

  always_ff @(posedge clk_bit or negedge rst_n) begin
    if (!rst_n) sdata_o <= 1'b0;
    else        sdata_o <= frame_active & next_bit;
  end

  p_idle_zero_r2: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !frame_active |=> !sdata_o);

  p_tag_ready_r3: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (frame_active && cur_slot == '0 && cur_bit == BPW'(TAG_BITS - 1))
      |=> (sdata_o == $past(snap.ready)));

endmodule

// File: tb/tb_aclink_infrm_ser.sv
`timescale 1ns/1ps
module tb_aclink_infrm_ser;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_in = 1'b0;
  logic        rdy = 1'b0;
  logic [1:0]  res = 2'd0;
  logic        rdv = 1'b0, lv = 1'b0, rv = 1'b0;
  logic [19:0] raddr = '0, rdata = '0, lsmp = '0, rsmp = '0;
  logic        sdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] e_tag;
  logic [19:0] e_w [0:12];

  always #10 clk = ~clk;

  aclink_infrm_ser dut (
    .clk_bit(clk), .rst_n(rst_n), .sync_in(sync_in), .codec_ready_i(rdy),
    .res_sel_i(res), .rd_valid_i(rdv), .rd_addr_i(raddr), .rd_data_i(rdata),
    .left_valid_i(lv), .left_sample_i(lsmp), .right_valid_i(rv),
    .right_sample_i(rsmp), .sdata_o(sdata)
  );

  task automatic check(input logic act, input logic exp, input string req, input int k);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s bit %0d: actual %b expected %b", req, k, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k);
    int s, b;
    if (k < 16) return e_tag[15-k];
    s = (k - 16) / 20 + 1;
    b = 19 - ((k - 16) % 20);
    return e_w[s][b];
  endfunction

  function automatic string req_of(input int k);
    if (k < 16) return "R3";
    if (k < 56) return "R4";
    if (k < 96) return "R5/R6";
    return "R7";
  endfunction

  // Starts a frame at the current negedge and checks nbits bits (R1, R8).
  task automatic run_frame(input bit r, input bit a_v, input bit l_v, input bit r_v,
                           input logic [1:0] rs, input logic [19:0] a, input logic [19:0] d,
                           input logic [19:0] l, input logic [19:0] rr,
                           input int nbits, input int hold);
    logic [19:0] mask;
    rdy = r; rdv = a_v; lv = l_v; rv = r_v; res = rs;
    raddr = a; rdata = d; lsmp = l; rsmp = rr;
    mask = (rs == 2'd0) ? 20'hFFFF0 : (rs == 2'd1) ? 20'hFFFFC : 20'hFFFFF;
    e_tag = {r, a_v, a_v, l_v, r_v, 11'b0};
    for (int i = 0; i <= 12; i++) e_w[i] = '0;
    e_w[1] = a_v ? a : '0;
    e_w[2] = a_v ? d : '0;
    e_w[3] = l_v ? (l & mask) : '0;
    e_w[4] = r_v ? (rr & mask) : '0;
    sync_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      if (k == hold) sync_in = 1'b0;
      if (k == 60) begin // R8: disturb every input mid-frame
        rdy = ~r; rdv = ~a_v; lv = ~l_v; rv = ~r_v; res = ~rs;
        raddr = ~a; rdata = ~d; lsmp = ~l; rsmp = ~rr;
      end
      @(posedge clk);
      @(negedge clk);
      check(sdata, exp_bit(k), (k >= 60 && k < 96) ? "R8" : req_of(k), k);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(sdata, 1'b0, "R10", -1);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(sdata, 1'b0, "R10", -1);
    end

    // R1, R3..R7: sweep resolution and flag combinations
    for (int rs = 0; rs < 4; rs++) begin
      for (int c = 0; c < 8; c++) begin
        logic [19:0] l, rr, a, d;
        l  = 20'(32'h9E3779B9 * (rs * 8 + c + 1));
        rr = {l[6:0], l[19:7]} ^ 20'h5A5A5;
        a  = 20'(c * 4096 + rs * 17 + 20'h80000);
        d  = ~l;
        run_frame(c[0], c[1], c[2], c[1] ^ c[2] ^ c[0], 2'(rs), a, d, l, rr, 256, 15);
        // R2: nothing after the last bit
        @(posedge clk); @(negedge clk);
        check(sdata, 1'b0, "R2", 256);
      end
    end

    // R6: all-ones samples show the tails clearly
    for (int rs = 0; rs < 3; rs++) begin
      run_frame(1'b1, 1'b1, 1'b1, 1'b1, 2'(rs), 20'hFFFFF, 20'hFFFFF,
                20'hFFFFF, 20'hFFFFF, 256, 15);
      @(posedge clk); @(negedge clk);
      check(sdata, 1'b0, "R2", 256);
    end

    // R2: sync held high through and beyond the frame does not restart
    run_frame(1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 20'h12345, 20'h6789A,
              20'hFEDCB, 20'h0F0F1, 256, 1000);
    repeat (10) begin
      @(posedge clk); @(negedge clk);
      check(sdata, 1'b0, "R2", 256);
    end
    sync_in = 1'b0;
    @(posedge clk); @(negedge clk);

    // R9: restart in the middle of a frame
    run_frame(1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 20'hAAAAA, 20'h55555,
              20'hC3C3C, 20'h3C3C3, 100, 15);
    run_frame(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 20'h0F00F, 20'hF00F0,
              20'h13579, 20'h2468A, 256, 15); // R9 restarted frame
    @(posedge clk); @(negedge clk);
    check(sdata, 1'b0, "R2", 256);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule